// File: doc/BRIEF.md
# Warp Subroutine Call and Reconvergence Stack

This block handles subroutine call and return for one warp, a group of threads that share a program counter and carry an active-thread mask. The decoder presents a call event or a return event, together with the current PC, the instruction length (4 or 8 bytes), the current mask and the call operands. A constant fetched from a constant bank arrives as an already-read word. The block registers the PC and mask that execution continues with. It also keeps a count of nested counted calls and three sticky error flags.

When a call is taken, the block saves three things in one stack entry: the next sequential address, the active mask at the moment of the call, and one bit that records whether the call counted toward the depth limit. A return removes the returning threads from the mask. The entry is popped only when no thread is left active. The warp then resumes at the saved address with the saved mask, so every thread that entered the subroutine reconverges there. Once the configured limit is reached, counted calls degrade to no-ops. A per-call flag exempts a call from the count.

Top module: `warp_call_stack`

## Requirements
- R1: The return address pushed by a taken call is `cur_pc + 4` when `wide_instr` is 0 and `cur_pc + 8` when it is 1. A pop outputs exactly this address.
- R2: With `call_kind` = 0 (relative), the target is the return address plus the sign-extended 24-bit `call_off`, with 32-bit wraparound.
- R3: With `call_kind` = 1, the target is `call_imm`. With `call_kind` = 2 or 3, the target is `const_word`. The unused operands have no effect.
- R4: Every call event leaves `next_mask` equal to `cur_mask`. A taken call sets `next_pc` to the target one cycle after the event.
- R5: A return whose `ret_mask` leaves some bit of `cur_mask` set gives `next_mask = cur_mask & ~ret_mask` and `next_pc` = `cur_pc` plus the instruction length. The stack is not popped.
- R6: A return that clears the last active thread pops the stack. `next_pc` and `next_mask` then take the saved address and the saved mask.
- R7: A taken call with `call_noinc` = 0 increments `call_depth`, and popping its entry decrements it. A call with `call_noinc` = 1 leaves `call_depth` unchanged on both its push and its pop.
- R8: When `call_depth` equals `CALL_LIMIT`, a call with `call_noinc` = 0 is a no-op. There is no push, no flag and no depth change, and `next_pc` is the return address.
- R9: A call whose target has a nonzero value in bits [1:0] sets `status[0]` (misaligned). The call is not taken: there is no push, `next_pc` is the return address, and `call_depth` is unchanged.
- R10: A call that would push onto a stack already holding `STACK_DEPTH` entries sets `status[1]` (overflow). Nothing is pushed, and `next_pc` is the return address.
- R11: A return that clears the last active thread while the stack is empty sets `status[2]` (underflow). `next_pc` advances by the instruction length and `next_mask` becomes zero.
- R12: Status flags stay set until `flag_clr` is high for a cycle, which clears all three. A flag raised in that same cycle still sets.
- R13: When `call_valid` and `ret_valid` are both high, the call is performed and the return is ignored.
- R14: After reset, `next_pc` = `RESET_PC`, `next_mask` is all ones, `call_depth` = 0 and `status` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_valid | input | 1 | Call event this cycle |
| call_kind | input | 2 | 0 relative, 1 immediate absolute, 2/3 constant-bank word |
| call_noinc | input | 1 | Exempt this call from the depth count |
| call_off | input | 24 | Signed relative offset |
| call_imm | input | 32 | Absolute immediate target |
| const_word | input | 32 | Target word already read from the constant bank |
| ret_valid | input | 1 | Return event this cycle |
| ret_mask | input | LANES | Threads executing the return |
| cur_pc | input | 32 | PC of the current instruction |
| wide_instr | input | 1 | Current instruction is 8 bytes long |
| cur_mask | input | LANES | Current active-thread mask |
| flag_clr | input | 1 | Clear all status flags |
| next_pc | output | 32 | Registered PC to continue at |
| next_mask | output | LANES | Registered active mask to continue with |
| call_depth | output | $clog2(CALL_LIMIT+1) | Number of counted calls outstanding |
| status | output | 3 | Sticky flags: [0] misaligned, [1] overflow, [2] underflow |

## Verification
Some properties are checked on every cycle. The stack is never pushed while full and never popped while empty. The depth stays within the limit and never moves by more than one per cycle. Calls always carry the mask through, exempt calls leave the depth alone, counted calls at the limit advance the PC without changing the depth, partial returns clear exactly the returning lanes, and flags persist until cleared. Other behaviour can only be shown by the directed scenarios, because it needs a full call and return history. This covers the exact target and return arithmetic, including negative offsets that wrap, and the restoration of the saved masks across nested calls. It also covers the matching of exempt and counted pops against the depth counter, proof through a later underflow that no-op and rejected calls pushed nothing, and the call-over-return priority.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  typedef enum logic [1:0] {
    CK_REL   = 2'd0,
    CK_IMM   = 2'd1,
    CK_CONST = 2'd2,
    CK_CONST_ALT = 2'd3
  } call_kind_e;

  localparam int ST_MISALIGN = 0;
  localparam int ST_OVERFLOW = 1;
  localparam int ST_UNDERFLOW = 2;
  localparam int ST_W = 3;
endpackage

// File: rtl/wcs_target.sv
module wcs_target (
  input  logic [31:0]        pc,
  input  logic               wide_instr,
  input  wcs_pkg::call_kind_e kind,
  input  logic [23:0]        rel_off,
  input  logic [31:0]        abs_imm,
  input  logic [31:0]        const_word,
  output logic [31:0]        seq_pc,
  output logic [31:0]        dest_pc,
  output logic               misaligned
);
  logic [31:0] rel_dest;

  always_comb begin
    seq_pc   = pc + (wide_instr ? 32'd8 : 32'd4);
    rel_dest = seq_pc + {{8{rel_off[23]}}, rel_off};
    case (kind)
      wcs_pkg::CK_REL: dest_pc = rel_dest;
      wcs_pkg::CK_IMM: dest_pc = abs_imm;
      default:         dest_pc = const_word;
    endcase
    misaligned = |dest_pc[1:0];
  end
endmodule

// File: rtl/wcs_stack.sv
module wcs_stack #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 65
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] top,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rd_q, byp_q;
  logic             byp;
  logic [LW-1:0]    cnt, cnt_nxt;
  logic [AW-1:0]    rd_addr, wr_addr;

  always_comb begin
    cnt_nxt = cnt;
    if (push)     cnt_nxt = cnt + LW'(1);
    else if (pop) cnt_nxt = cnt - LW'(1);
    rd_addr = (cnt_nxt == '0) ? '0 : AW'(cnt_nxt - LW'(1));
    wr_addr = AW'(cnt);
  end

  // Array without reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (push) mem[wr_addr] <= wdata;
    rd_q <= mem[rd_addr];
  end

  // A push writes the word that becomes the new top; forward it.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      byp   <= 1'b0;
      byp_q <= '0;
    end else begin
      cnt   <= cnt_nxt;
      byp   <= push;
      byp_q <= wdata;
    end
  end

  assign top   = byp ? byp_q : rd_q;
  assign full  = (cnt == LW'(DEPTH));
  assign empty = (cnt == '0);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    !(push && full));
  p_no_underflow_r11: assert property (@(posedge clk) disable iff (rst)
    !(pop && empty));
  p_level_step_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + LW'(1)) || (cnt == $past(cnt) - LW'(1)));
endmodule

// File: rtl/warp_call_stack.sv
module warp_call_stack #(
  parameter int          LANES       = 32,
  parameter int          STACK_DEPTH = 16,
  parameter int          CALL_LIMIT  = 12,
  parameter logic [31:0] RESET_PC    = 32'h0
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              call_valid,
  input  logic [1:0]                        call_kind,
  input  logic                              call_noinc,
  input  logic [23:0]                       call_off,
  input  logic [31:0]                       call_imm,
  input  logic [31:0]                       const_word,
  input  logic                              ret_valid,
  input  logic [LANES-1:0]                  ret_mask,
  input  logic [31:0]                       cur_pc,
  input  logic                              wide_instr,
  input  logic [LANES-1:0]                  cur_mask,
  input  logic                              flag_clr,
  output logic [31:0]                       next_pc,
  output logic [LANES-1:0]                  next_mask,
  output logic [$clog2(CALL_LIMIT+1)-1:0]   call_depth,
  output logic [2:0]                        status
);
  import wcs_pkg::*;

  localparam int DW      = $clog2(CALL_LIMIT + 1);
  localparam int ENTRY_W = 32 + LANES + 1;

  logic [31:0]        seq_pc, dest_pc;
  logic               misaligned;
  logic [ENTRY_W-1:0] top_ent, wdata;
  logic               stk_full, stk_empty;
  logic               push, pop, counted, at_limit;
  logic [LANES-1:0]   remaining;
  logic [31:0]        top_pc;
  logic [LANES-1:0]   top_mask;
  logic               top_counted;

  logic [31:0]        pc_q;
  logic [LANES-1:0]   mask_q;
  logic [DW-1:0]      depth_q;
  logic [ST_W-1:0]    flags_q;

  wcs_target u_target (
    .pc         (cur_pc),
    .wide_instr (wide_instr),
    .kind       (call_kind_e'(call_kind)),
    .rel_off    (call_off),
    .abs_imm    (call_imm),
    .const_word (const_word),
    .seq_pc     (seq_pc),
    .dest_pc    (dest_pc),
    .misaligned (misaligned)
  );

  wcs_stack #(.DEPTH(STACK_DEPTH), .WIDTH(ENTRY_W)) u_stack (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .pop   (pop),
    .wdata (wdata),
    .top   (top_ent),
    .full  (stk_full),
    .empty (stk_empty)
  );

  assign top_pc      = top_ent[ENTRY_W-1 -: 32];
  assign top_mask    = top_ent[LANES:1];
  assign top_counted = top_ent[0];

  always_comb begin
    counted   = !call_noinc;
    at_limit  = counted && (depth_q == DW'(CALL_LIMIT));
    remaining = cur_mask & ~ret_mask;
    wdata     = {seq_pc, cur_mask, counted};
    push      = 1'b0;
    pop       = 1'b0;
    if (call_valid) begin
      push = !at_limit && !misaligned && !stk_full;
    end else if (ret_valid) begin
      pop = (remaining == '0) && !stk_empty;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= RESET_PC;
      mask_q  <= '1;
      depth_q <= '0;
      flags_q <= '0;
    end else begin
      if (flag_clr) flags_q <= '0;
      if (call_valid) begin
        mask_q <= cur_mask;
        if (push) begin
          pc_q <= dest_pc;
          if (counted) depth_q <= depth_q + DW'(1);
        end else begin
          pc_q <= seq_pc;
          if (!at_limit) begin
            if (misaligned) flags_q[ST_MISALIGN] <= 1'b1;
            else            flags_q[ST_OVERFLOW] <= 1'b1;
          end
        end
      end else if (ret_valid) begin
        if (pop) begin
          pc_q   <= top_pc;
          mask_q <= top_mask;
          if (top_counted) depth_q <= depth_q - DW'(1);
        end else begin
          pc_q   <= seq_pc;
          mask_q <= remaining;
          if (remaining == '0) flags_q[ST_UNDERFLOW] <= 1'b1;
        end
      end
    end
  end

  assign next_pc    = pc_q;
  assign next_mask  = mask_q;
  assign call_depth = depth_q;
  assign status     = flags_q;

  p_depth_bound_r8: assert property (@(posedge clk) disable iff (rst)
    depth_q <= DW'(CALL_LIMIT));
  p_limit_noop_r8: assert property (@(posedge clk) disable iff (rst)
    (call_valid && !call_noinc && call_depth == DW'(CALL_LIMIT))
      |=> (next_pc == $past(seq_pc)) && $stable(call_depth));
  p_noinc_depth_r7: assert property (@(posedge clk) disable iff (rst)
    (call_valid && call_noinc) |=> $stable(call_depth));
  p_call_mask_r4: assert property (@(posedge clk) disable iff (rst)
    call_valid |=> next_mask == $past(cur_mask));
  p_partial_ret_r5: assert property (@(posedge clk) disable iff (rst)
    (!call_valid && ret_valid && ((cur_mask & ~ret_mask) != '0))
      |=> (next_mask == $past(cur_mask & ~ret_mask)) && (next_pc == $past(seq_pc)));
  p_flag_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    !flag_clr |=> ((status & $past(status)) == $past(status)));
endmodule

// File: tb/test_warp_call_stack.sv
module test_warp_call_stack;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        call_valid = 1'b0;
  logic [1:0]  call_kind = 2'd0;
  logic        call_noinc = 1'b0;
  logic [23:0] call_off = '0;
  logic [31:0] call_imm = '0;
  logic [31:0] const_word = '0;
  logic        ret_valid = 1'b0;
  logic [31:0] ret_mask = '0;
  logic [31:0] cur_pc = '0;
  logic        wide_instr = 1'b0;
  logic [31:0] cur_mask = '1;
  logic        flag_clr = 1'b0;
  logic [31:0] next_pc;
  logic [31:0] next_mask;
  logic [3:0]  call_depth;
  logic [2:0]  status;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  warp_call_stack i_warp_call_stack (
    .clk(clk), .rst(rst), .call_valid(call_valid), .call_kind(call_kind),
    .call_noinc(call_noinc), .call_off(call_off), .call_imm(call_imm),
    .const_word(const_word), .ret_valid(ret_valid), .ret_mask(ret_mask),
    .cur_pc(cur_pc), .wide_instr(wide_instr), .cur_mask(cur_mask),
    .flag_clr(flag_clr), .next_pc(next_pc), .next_mask(next_mask),
    .call_depth(call_depth), .status(status)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic issue_call(input logic [1:0] k, input logic nz, input logic [23:0] off,
                            input logic [31:0] imm, input logic [31:0] cw,
                            input logic [31:0] pc, input logic w, input logic [31:0] m);
    call_valid = 1'b1; call_kind = k; call_noinc = nz; call_off = off;
    call_imm = imm; const_word = cw; cur_pc = pc; wide_instr = w; cur_mask = m;
    tick();
    call_valid = 1'b0; call_noinc = 1'b0;
  endtask

  task automatic issue_ret(input logic [31:0] pc, input logic w,
                           input logic [31:0] m, input logic [31:0] rm);
    ret_valid = 1'b1; cur_pc = pc; wide_instr = w; cur_mask = m; ret_mask = rm;
    tick();
    ret_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R14 pc", next_pc, 32'h0);
    check("R14 mask", next_mask, 32'hFFFF_FFFF);
    check("R14 depth", 32'(call_depth), 0);
    check("R14 status", 32'(status), 0);
  endtask

  task automatic t_relative_nested();
    issue_call(2'd0, 1'b0, 24'h000040, 32'h0, 32'h0, 32'h100, 1'b0, 32'hFFFF_FFFF);
    check("R2 fwd target", next_pc, 32'h144);
    check("R4 mask kept", next_mask, 32'hFFFF_FFFF);
    check("R7 depth inc", 32'(call_depth), 1);
    issue_call(2'd0, 1'b0, 24'hFFFFE0, 32'h0, 32'h0, 32'h1000, 1'b1, 32'h0000_FFFF);
    check("R2 neg offset wide", next_pc, 32'h0000_0FE8);
    check("R4 mask kept 2", next_mask, 32'h0000_FFFF);
    issue_call(2'd0, 1'b0, 24'hFFFF00, 32'h0, 32'h0, 32'h10, 1'b0, 32'h0000_00FF);
    check("R2 wraparound", next_pc, 32'hFFFF_FF14);
    check("R7 depth 3", 32'(call_depth), 3);
    issue_ret(32'hFFFF_FF20, 1'b0, 32'h0000_00FF, 32'h0000_000F);
    check("R5 partial mask", next_mask, 32'h0000_00F0);
    check("R5 partial pc", next_pc, 32'hFFFF_FF24);
    check("R5 no pop depth", 32'(call_depth), 3);
    issue_ret(32'hFFFF_FF30, 1'b1, 32'h0000_00F0, 32'h0000_00F0);
    check("R6 pop pc", next_pc, 32'h14);
    check("R6 pop mask", next_mask, 32'h0000_00FF);
    check("R7 depth dec", 32'(call_depth), 2);
    issue_ret(32'h2000, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF);
    check("R1 wide return addr", next_pc, 32'h1008);
    check("R6 mask level 2", next_mask, 32'h0000_FFFF);
    issue_ret(32'h3000, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R1 narrow return addr", next_pc, 32'h104);
    check("R6 mask level 1", next_mask, 32'hFFFF_FFFF);
    check("R7 depth zero", 32'(call_depth), 0);
  endtask

  task automatic t_absolute_noinc();
    issue_call(2'd1, 1'b0, 24'h000100, 32'h0012_8000, 32'h0000_4444, 32'h200, 1'b0, 32'hFFFF_FFFF);
    check("R3 imm target", next_pc, 32'h0012_8000);
    check("R7 counted", 32'(call_depth), 1);
    issue_call(2'd2, 1'b1, 24'h000100, 32'hDEAD_0000, 32'h0000_2000, 32'h0012_8000, 1'b1, 32'hFFFF_FFFF);
    check("R3 const target", next_pc, 32'h2000);
    check("R7 noinc push", 32'(call_depth), 1);
    issue_ret(32'h2010, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R1 const ret addr", next_pc, 32'h0012_8008);
    check("R7 noinc pop", 32'(call_depth), 1);
    issue_ret(32'h0012_8100, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R6 outer pop", next_pc, 32'h204);
    check("R7 counted pop", 32'(call_depth), 0);
  endtask

  task automatic t_misalign_underflow();
    issue_call(2'd1, 1'b0, 24'h0, 32'h0000_0102, 32'h0, 32'h300, 1'b0, 32'hFFFF_FFFF);
    check("R9 flag", 32'(status), 32'h1);
    check("R9 not taken pc", next_pc, 32'h304);
    check("R9 depth", 32'(call_depth), 0);
    tick();
    check("R12 sticky", 32'(status), 32'h1);
    issue_ret(32'h500, 1'b0, 32'h1, 32'h1);
    check("R11 underflow flag", 32'(status), 32'h5);
    check("R11 pc", next_pc, 32'h504);
    check("R11 mask", next_mask, 32'h0);
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
    check("R12 clear", 32'(status), 32'h0);
  endtask

  task automatic t_limit_overflow();
    do_reset();
    for (int i = 0; i < 12; i++)
      issue_call(2'd1, 1'b0, 24'h0, 32'h8000 + 32'(i) * 32'h100, 32'h0,
                 32'h1000 * 32'(i + 1), 1'b0, 32'hFFFF_FFFF);
    check("R7 depth at limit", 32'(call_depth), 12);
    issue_call(2'd1, 1'b0, 24'h0, 32'h9000, 32'h0, 32'h40000, 1'b0, 32'hFFFF_FFFF);
    check("R8 noop pc", next_pc, 32'h40004);
    check("R8 noop depth", 32'(call_depth), 12);
    check("R8 noop no flag", 32'(status), 0);
    for (int j = 0; j < 4; j++)
      issue_call(2'd1, 1'b1, 24'h0, 32'hA000, 32'h0, 32'h50000 + 32'(j) * 32'h100,
                 1'b0, 32'hFFFF_FFFF);
    check("R8 noinc beyond limit", 32'(status), 0);
    check("R8 noinc target", next_pc, 32'hA000);
    issue_call(2'd1, 1'b1, 24'h0, 32'hA000, 32'h0, 32'h60000, 1'b0, 32'hFFFF_FFFF);
    check("R10 overflow flag", 32'(status), 32'h2);
    check("R10 overflow pc", next_pc, 32'h60004);
    for (int j = 3; j >= 0; j--) begin
      issue_ret(32'h7000, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      check("R10 noinc pop pc", next_pc, 32'h50004 + 32'(j) * 32'h100);
      check("R7 noinc pop depth", 32'(call_depth), 12);
    end
    for (int k = 11; k >= 0; k--) begin
      issue_ret(32'h7000, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      check("R6 counted pop pc", next_pc, 32'h1000 * 32'(k + 1) + 32'h4);
      check("R7 counted pop depth", 32'(call_depth), 32'(k));
    end
    issue_ret(32'h7000, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R10 nothing extra pushed", 32'(status), 32'h6);
  endtask

  task automatic t_priority();
    do_reset();
    ret_valid = 1'b1; ret_mask = 32'hFFFF_FFFF;
    issue_call(2'd1, 1'b0, 24'h0, 32'h3000, 32'h0, 32'h800, 1'b0, 32'h0000_00FF);
    ret_valid = 1'b0;
    check("R13 call wins pc", next_pc, 32'h3000);
    check("R13 call wins mask", next_mask, 32'h0000_00FF);
    check("R13 call wins depth", 32'(call_depth), 1);
    issue_ret(32'h3008, 1'b0, 32'h0000_00FF, 32'h0000_00FF);
    check("R13 pushed entry", next_pc, 32'h804);
    check("R13 no flags", 32'(status), 0);
  endtask

  initial begin
    t_reset();
    t_relative_nested();
    t_absolute_noinc();
    t_misalign_underflow();
    t_limit_overflow();
    t_priority();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule